// File: doc/BRIEF.md
# Pinless Power-On Reset Sequencer

This block makes a design-wide reset from nothing but the running clock. No reset package pin and no reset input are involved. A short shift chain powers up holding ones, which come from the declaration initial values of its flops. From the first clock edge on, zeros shift in. The generated reset is held while a one is still at the chain's last stage. The chain's own flops take no reset connection, so the reset it produces can never hold the generator in reset. Two forms of the reset leave the block: an active-low line for the whole design and an active-high copy for local logic.

Release of a global reset reaches flops across the device at widely different times. Because of this, a startup state machine walks through a holding state and a counted settle state before it enters the run state. It raises a ready flag only on entering that run state. That flag is also the ready half of a valid/ready event port. Events are sums added into an accumulator that the generated reset clears. Only a beat with both valid and ready high is taken. A beat offered while ready is low is dropped, not held. The sender keeps its data until ready is high, and ready never falls once it has risen.

Top module: `por_sequencer`

## Requirements
- R1: Before the first clock edge, with no reset input of any kind, `rst_n` is 0, `rst` is 1, `ev_ready` is 0 and `acc` is 0. All of these come from power-up initial values.
- R2: `rst_n` stays 0 after clock edges 1 through DEPTH-1 and becomes 1 after edge DEPTH. DEPTH defaults to 4 and must be at least 2.
- R3: `rst` is at every sample the inverse of `rst_n`.
- R4: Once `rst_n` has gone high it never returns low while the clock runs. The chain flops are not connected to the reset they produce.
- R5: `ev_ready` stays 0 until edge DEPTH+SETTLE and becomes 1 after that edge. SETTLE defaults to 3 and must be at least 2. Before that edge the state machine passes through a holding state and a settle state.
- R6: Once `ev_ready` is 1 it stays 1.
- R7: A beat with `ev_valid`=1 at an edge where `ev_ready` was 0 leaves `acc` unchanged. This includes the edge at which `ev_ready` rises.
- R8: At an edge with `ev_ready`=1 and `ev_valid`=1, `acc` becomes (`acc` + `ev_data`) mod 2^DW. With `ev_valid`=0, `acc` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| ev_valid | input | 1 | Event beat offered |
| ev_data | input | DW | Event value to add |
| ev_ready | output | 1 | Startup done; event beats are taken |
| rst_n | output | 1 | Design-wide reset, active low |
| rst | output | 1 | Local reset, active high |
| acc | output | DW | Running sum of taken event values |

## Verification
The hardest case to reach is an event beat that lands exactly on the edge where ready rises. Ready was still low at that edge, so the beat must be dropped. The bench holds `ev_valid` high with a nonzero value from time zero through that edge. It then confirms that `acc` is still zero, counting edges from power-up without any reset of its own. The wrap of the accumulator and the lasting hold of reset release are reached afterwards, through a table of event beats and a long idle stretch.

// File: rtl/por_pkg.sv
package por_pkg;
  typedef enum logic [1:0] {
    ST_HOLD   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_RUN    = 2'd2
  } por_state_e;
endpackage

// File: rtl/por_shift_chain.sv
module por_shift_chain #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  output logic hold_o
);
  // Power-up value of all ones; no reset input reaches these flops.
  logic [DEPTH-1:0] stage_q = '1;

  always_ff @(posedge clk) begin
    stage_q <= {stage_q[DEPTH-2:0], 1'b0};
  end

  assign hold_o = stage_q[DEPTH-1];

  AST_NO_REARM: assert property (@(posedge clk) !hold_o |=> !hold_o); // R4
endmodule

// File: rtl/por_startup_fsm.sv
module por_startup_fsm
  import por_pkg::*;
#(
  parameter int SETTLE = 3
) (
  input  logic clk,
  input  logic rst_n,
  output logic ready_o
);
  localparam int CW = $clog2(SETTLE + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE - 1);

  por_state_e    state_q = ST_HOLD;
  logic [CW-1:0] cnt_q   = '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HOLD;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_HOLD: begin
          if (cnt_q == LAST) begin
            state_q <= ST_RUN;
          end else begin
            state_q <= ST_SETTLE;
            cnt_q   <= cnt_q + 1'b1;
          end
        end
        ST_SETTLE: begin
          if (cnt_q == LAST) state_q <= ST_RUN;
          else cnt_q <= cnt_q + 1'b1;
        end
        ST_RUN:  state_q <= ST_RUN;
        default: state_q <= ST_HOLD;
      endcase
    end
  end

  assign ready_o = (state_q == ST_RUN);

  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> ready_o); // R6
  AST_READY_VIA_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> $past(state_q) != ST_HOLD || SETTLE < 2); // R5
  AST_NOT_READY_IN_RESET: assert property (@(posedge clk)
    !rst_n |-> !ready_o); // R5
endmodule

// File: rtl/por_event_gate.sv
module por_event_gate #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          open_i,
  input  logic          valid_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] acc_o
);
  logic [DW-1:0] acc_q = '0;
  logic          take;

  assign take = open_i & valid_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else if (take) acc_q <= acc_q + data_i;
  end

  assign acc_o = acc_q;

  AST_CLOSED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !open_i |=> $stable(acc_q)); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (open_i && !valid_i) |=> $stable(acc_q)); // R8
endmodule

// File: rtl/por_sequencer.sv
module por_sequencer #(
  parameter int DEPTH  = 4,
  parameter int SETTLE = 3,
  parameter int DW     = 8
) (
  input  logic          clk,
  input  logic          ev_valid,
  input  logic [DW-1:0] ev_data,
  output logic          ev_ready,
  output logic          rst_n,
  output logic          rst,
  output logic [DW-1:0] acc
);
  logic hold;

  por_shift_chain #(.DEPTH(DEPTH)) u_chain (
    .clk    (clk),
    .hold_o (hold)
  );

  assign rst   = hold;
  assign rst_n = ~hold;

  por_startup_fsm #(.SETTLE(SETTLE)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .ready_o (ev_ready)
  );

  por_event_gate #(.DW(DW)) u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .open_i  (ev_ready),
    .valid_i (ev_valid),
    .data_i  (ev_data),
    .acc_o   (acc)
  );
endmodule

// File: tb/tb_por_sequencer.sv
module tb_por_sequencer;
  localparam int DEPTH  = 4;
  localparam int SETTLE = 3;
  localparam int DW     = 8;
  localparam int NV     = 8;

  // {valid, data, expected acc after the edge}
  localparam logic [16:0] VEC [NV] = '{
    {1'b1, 8'd3,   8'd3},
    {1'b0, 8'd9,   8'd3},
    {1'b1, 8'd250, 8'd253},
    {1'b1, 8'd10,  8'd7},
    {1'b0, 8'd0,   8'd7},
    {1'b1, 8'd255, 8'd6},
    {1'b1, 8'd0,   8'd6},
    {1'b1, 8'd1,   8'd7}
  };

  logic          clk = 1'b0;
  logic          ev_valid = 1'b0;
  logic [DW-1:0] ev_data = '0;
  logic          ev_ready, rst_n, rst;
  logic [DW-1:0] acc;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  por_sequencer #(.DEPTH(DEPTH), .SETTLE(SETTLE), .DW(DW)) dut (
    .clk(clk), .ev_valid(ev_valid), .ev_data(ev_data),
    .ev_ready(ev_ready), .rst_n(rst_n), .rst(rst), .acc(acc)
  );

  always #2 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      checks++;
      fails++;
      $display("FAIL R5 watchdog actual=%0d expected=<5000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1: power-up state before any edge
    ev_valid = 1'b1;
    ev_data  = 8'd5;
    #1;
    chk("R1 rst_n", int'(rst_n), 0);
    chk("R1 rst", int'(rst), 1);
    chk("R1 ev_ready", int'(ev_ready), 0);
    chk("R1 acc", int'(acc), 0);

    // Walk edges through reset release and settle, beats offered throughout
    for (int n = 1; n <= DEPTH + SETTLE; n++) begin
      @(posedge clk);
      #1;
      chk("R2 rst_n timing", int'(rst_n), (n >= DEPTH) ? 1 : 0);
      chk("R3 rst inverse", int'(rst), (n >= DEPTH) ? 0 : 1);
      chk("R5 ev_ready timing", int'(ev_ready), (n >= DEPTH + SETTLE) ? 1 : 0);
      chk("R7 acc before ready", int'(acc), 0);
    end
    ev_valid = 1'b0;

    // Table of event beats
    for (int i = 0; i < NV; i++) begin
      ev_valid = VEC[i][16];
      ev_data  = VEC[i][15:8];
      @(posedge clk);
      #1;
      chk("R8 acc", int'(acc), int'(VEC[i][7:0]));
      chk("R6 ev_ready held", int'(ev_ready), 1);
    end
    ev_valid = 1'b0;

    // Long idle: reset never returns, ready and acc hold
    for (int k = 0; k < 40; k++) begin
      @(posedge clk);
      #1;
      chk("R4 rst_n stays high", int'(rst_n), 1);
      chk("R3 rst low", int'(rst), 0);
    end
    chk("R6 ev_ready final", int'(ev_ready), 1);
    chk("R8 acc hold", int'(acc), 7);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule